// File: doc/BRIEF.md
# Predicated Vector Shift by Wide Elements

This unit shifts every narrow element of a vector operand by an amount drawn from a 64-bit lane of a second operand. The element size can be 8, 16 or 32 bits. Each 64-bit lane of the amount operand supplies one unsigned amount, and every narrow element inside the same 64-bit span of the data operand uses it. Arithmetic right, logical right and logical left shifts are supported.

A per-byte predicate masks the update. The data operand is also the destination, so an inactive element comes out unchanged. The unit decodes an operation field and a size field. It reports the reserved size as an undefined encoding and writes nothing in that case. An operation code outside the three shift codes is not treated as this instruction and produces no output activity.

The vector width is the parameter `VLEN`. It must be a multiple of 128 bits, from 128 to 512. The shift datapath is combinational, and the result is registered one cycle after the input strobe.

Top module: `vshw_unit`

## Requirements
- R1: A strobe on `in_valid` with a supported size and a shift opcode loads `res` and raises `res_valid` for exactly one cycle at the next rising clock edge.
- R2: The opcode `opc` selects the shift: 3'b000 is arithmetic right, 3'b001 is logical right and 3'b011 is logical left. Any other code raises neither flag and leaves `res` unchanged.
- R3: The size field `size` gives the element width: 2'b00 is 8-bit, 2'b01 is 16-bit and 2'b10 is 32-bit. Element i occupies bits [i*W+W-1 : i*W].
- R4: The amount for an element is the whole unsigned 64-bit value `zm[64k+63:64k]`, where k is the 64-bit lane that holds the element.
- R5: Predicate bit j (`pg[j]`) belongs to byte j of the vector. An element is active when the bit of its lowest byte is 1, and the bits of its other bytes are ignored.
- R6: An inactive element appears in `res` with its `zdn` value.
- R7: An amount at or above the element width makes a logical shift return 0 and an arithmetic shift return copies of the sign bit. All 64 amount bits take part in this comparison, so 2^32+1 counts as out of range.
- R8: An arithmetic right shift fills with the element's sign bit. A logical right shift fills with zeros from the top, and a left shift fills with zeros from the bottom.
- R9: Size 2'b11 with a shift opcode raises `undef_enc` for one cycle at the next edge. In that case `res_valid` stays low and `res` keeps its value.
- R10: While `rst_n` is low at a clock edge, `res` clears to zero and both flags go low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand strobe |
| zdn | input | VLEN | Data operand and old destination value |
| zm | input | VLEN | Shift amounts, one per 64-bit lane |
| pg | input | VLEN/8 | Per-byte predicate |
| size | input | 2 | Element size code |
| opc | input | 3 | Operation code |
| res | output | VLEN | Registered result vector |
| res_valid | output | 1 | Result loaded this cycle |
| undef_enc | output | 1 | Reserved size seen with a shift opcode |

## Verification
There is one register stage between the inputs and the outputs. The result, `res_valid` and `undef_enc` are therefore all due at the first rising edge after the strobe. The bench drives the inputs on a falling edge and drops `in_valid` on the next falling edge. It samples all three outputs at that second falling edge, half a period after they are loaded. Hold checks for the reserved size and for foreign opcodes read `res` at the same point, after the ignored strobe and before any other stimulus.

// File: rtl/vshw_pkg.sv
// Shared types for the wide-amount vector shift unit.
// Assumes: the element size and the operation are each decoded once at the top.
package vshw_pkg;
    typedef enum logic [1:0] {
        SH_ASR = 2'd0,
        SH_LSR = 2'd1,
        SH_LSL = 2'd2
    } shift_op_e;

    localparam int LANE_W = 64;
    localparam int NUM_SIZES = 3;
endpackage

// File: rtl/vshw_decode.sv
// Decodes the operation and size fields of a wide-amount shift.
// Assumes: the caller qualifies the outputs with its own strobe.
module vshw_decode
    import vshw_pkg::*;
(
    input  logic [2:0] opc,
    input  logic [1:0] size,
    output shift_op_e  op,
    output logic       op_ok,
    output logic       size_bad
);
    // Map the three shift opcodes to an operation; anything else is foreign.
    always_comb begin
        op    = SH_ASR;
        op_ok = 1'b1;
        case (opc)
            3'b000:  op = SH_ASR;
            3'b001:  op = SH_LSR;
            3'b011:  op = SH_LSL;
            default: op_ok = 1'b0;
        endcase
    end

    // The largest size code is reserved.
    always_comb size_bad = (size == 2'b11);
endmodule

// File: rtl/vshw_lane.sv
// One 64-bit lane: shifts each narrow element by the lane's 64-bit amount
// and keeps elements whose lowest predicate bit is clear.
// Assumes: size is 0..2 whenever the output is used; code 3 passes src through.
module vshw_lane
    import vshw_pkg::*;
(
    input  logic [LANE_W-1:0]   src,
    input  logic [LANE_W-1:0]   amt,
    input  logic [LANE_W/8-1:0] pred,
    input  logic [1:0]          size,
    input  shift_op_e           op,
    output logic [LANE_W-1:0]   dst
);
    logic [LANE_W-1:0] per_size [NUM_SIZES];

    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_sz
        localparam int W   = 8 << s;
        localparam int N   = LANE_W / W;
        localparam int SW  = $clog2(W);
        localparam int BPE = W / 8;

        logic          big;
        logic [SW-1:0] sh;
        logic [LANE_W-1:0] merged;

        assign big = |amt[LANE_W-1:SW];
        assign sh  = amt[SW-1:0];

        for (genvar e = 0; e < N; e++) begin : g_el
            logic [W-1:0] x;
            logic [W-1:0] r;
            assign x = src[e*W +: W];

            // Shift one element, saturating when the amount reaches the width.
            always_comb begin
                case (op)
                    SH_ASR:  r = big ? {W{x[W-1]}} : W'($signed(x) >>> sh);
                    SH_LSR:  r = big ? '0 : (x >> sh);
                    SH_LSL:  r = big ? '0 : (x << sh);
                    default: r = x;
                endcase
            end

            assign merged[e*W +: W] = pred[e*BPE] ? r : x;
        end

        assign per_size[s] = merged;
    end

    // Pick the lane result for the requested element size.
    always_comb begin
        case (size)
            2'b00:   dst = per_size[0];
            2'b01:   dst = per_size[1];
            2'b10:   dst = per_size[2];
            default: dst = src;
        endcase
    end
endmodule

// File: rtl/vshw_unit.sv
// Predicated vector shift by wide elements, one register stage.
// Assumes: VLEN is a multiple of 128 in 128..512; zdn is also the old destination.
module vshw_unit
    import vshw_pkg::*;
#(
    parameter int VLEN = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [VLEN-1:0]   zdn,
    input  logic [VLEN-1:0]   zm,
    input  logic [VLEN/8-1:0] pg,
    input  logic [1:0]        size,
    input  logic [2:0]        opc,
    output logic [VLEN-1:0]   res,
    output logic              res_valid,
    output logic              undef_enc
);
    localparam int LANES = VLEN / LANE_W;
    localparam int PB    = LANE_W / 8;

    if ((VLEN % 128) != 0 || VLEN < 128 || VLEN > 512) begin : g_bad_vlen
        $error("vshw_unit: VLEN must be a multiple of 128 in 128..512");
    end

    shift_op_e       op;
    logic            op_ok;
    logic            size_bad;
    logic [VLEN-1:0] nxt;
    logic            do_write;
    logic            do_undef;

    vshw_decode u_dec (
        .opc      (opc),
        .size     (size),
        .op       (op),
        .op_ok    (op_ok),
        .size_bad (size_bad)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        vshw_lane u_lane (
            .src  (zdn[k*LANE_W +: LANE_W]),
            .amt  (zm[k*LANE_W +: LANE_W]),
            .pred (pg[k*PB +: PB]),
            .size (size),
            .op   (op),
            .dst  (nxt[k*LANE_W +: LANE_W])
        );
    end

    // Qualify the strobe into a write or a reserved-size report.
    always_comb begin
        do_write = in_valid && op_ok && !size_bad;
        do_undef = in_valid && op_ok && size_bad;
    end

    // Output register: load the result only on a legal strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res       <= '0;
            res_valid <= 1'b0;
            undef_enc <= 1'b0;
        end else begin
            res_valid <= do_write;
            undef_enc <= do_undef;
            if (do_write) res <= nxt;
        end
    end

    p_flags_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_valid && undef_enc));
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> $stable(res));
    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ($past(in_valid) && $past(size) != 2'b11));
    p_undef_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        undef_enc |-> ($past(in_valid) && $past(size) == 2'b11));
    p_foreign_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opc[2]) |=> !(res_valid || undef_enc));
endmodule

// File: tb/vshw_unit_test.sv
module vshw_unit_test;
    localparam int VL = 256;
    localparam int LN = VL / 64;
    localparam int PW = VL / 8;
    localparam int NT = 12;

    localparam logic [1:0]  T_SZ [NT] = '{2'd0, 2'd0, 2'd0, 2'd1, 2'd1, 2'd1,
                                         2'd2, 2'd2, 2'd2, 2'd1, 2'd0, 2'd2};
    localparam logic [2:0]  T_OP [NT] = '{3'b000, 3'b001, 3'b011, 3'b000, 3'b001, 3'b011,
                                         3'b000, 3'b001, 3'b011, 3'b000, 3'b011, 3'b000};
    localparam logic [63:0] T_D  [NT] = '{64'h807F01FFC04010F0, 64'h807F01FFC04010F0,
                                         64'h807F01FFC04010F0, 64'h80007FFF1234F00F,
                                         64'h80007FFF1234F00F, 64'h80007FFF1234F00F,
                                         64'h8000000012345678, 64'hF000000087654321,
                                         64'hF000000087654321, 64'hC0017001A5A5FFFF,
                                         64'h0123456789ABCDEF, 64'h8765432112345678};
    localparam logic [63:0] T_A  [NT] = '{64'd3, 64'd3, 64'd3, 64'd15, 64'd16, 64'd0,
                                         64'h0000000100000001, 64'd31, 64'd32,
                                         64'h8000000000000000, 64'd7, 64'd4};
    localparam logic [7:0]  T_P  [NT] = '{8'hFF, 8'hFF, 8'hAA, 8'hFF, 8'hFF, 8'h55,
                                         8'hFF, 8'h0F, 8'hFF, 8'h33, 8'h01, 8'h0E};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [VL-1:0] zdn = '0;
    logic [VL-1:0] zm = '0;
    logic [PW-1:0] pg = '0;
    logic [1:0]    size = '0;
    logic [2:0]    opc = '0;
    logic [VL-1:0] res;
    logic          res_valid;
    logic          undef_enc;

    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    vshw_unit #(.VLEN(VL)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .zdn(zdn), .zm(zm),
        .pg(pg), .size(size), .opc(opc), .res(res), .res_valid(res_valid),
        .undef_enc(undef_enc)
    );

    // Reference result built from the requirement text.
    function automatic logic [VL-1:0] ref_model(logic [VL-1:0] d, logic [VL-1:0] a,
                                                logic [PW-1:0] p, logic [1:0] sz,
                                                logic [2:0] oc);
        logic [VL-1:0] o = d;
        int w = 8 << sz;
        logic [63:0] mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        for (int e = 0; e < VL / w; e++) begin
            logic [63:0] x = '0;
            logic [63:0] amt = a[((e * w) / 64) * 64 +: 64];
            logic [63:0] r;
            for (int b = 0; b < w; b++) x[b] = d[e * w + b];
            if (x[w - 1]) x = x | ~mask;
            case (oc)
                3'b000:  r = (amt >= 64'(w)) ? (x[63] ? mask : 64'd0)
                                             : (64'($signed(x) >>> amt) & mask);
                3'b001:  r = (amt >= 64'(w)) ? 64'd0 : ((x & mask) >> amt);
                default: r = (amt >= 64'(w)) ? 64'd0 : (((x & mask) << amt) & mask);
            endcase
            if (p[(e * w) / 8])
                for (int b = 0; b < w; b++) o[e * w + b] = r[b];
        end
        return o;
    endfunction

    task automatic check(string req, logic [VL-1:0] act, logic [VL-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one strobe on a falling edge and sample half a period after the load edge.
    task automatic issue(logic [VL-1:0] d, logic [VL-1:0] a, logic [PW-1:0] p,
                         logic [1:0] sz, logic [2:0] oc);
        @(negedge clk);
        zdn = d; zm = a; pg = p; size = sz; opc = oc; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_and_check(string req, logic [VL-1:0] d, logic [VL-1:0] a,
                                 logic [PW-1:0] p, logic [1:0] sz, logic [2:0] oc);
        logic [VL-1:0] e = ref_model(d, a, p, sz, oc);
        issue(d, a, p, sz, oc);
        check({req, " valid"}, VL'(res_valid), VL'(1));
        check({req, " data"}, res, e);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [VL-1:0] d, a, held;
        logic [PW-1:0] p;
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 res", res, '0);
        check("R10 res_valid", VL'(res_valid), '0);
        check("R10 undef_enc", VL'(undef_enc), '0);
        rst_n = 1'b1;

        // Table walk: R1 R2 R3 R5 R6 R7 R8
        for (int t = 0; t < NT; t++) begin
            for (int k = 0; k < LN; k++) begin
                d[k*64 +: 64] = T_D[t] + 64'(k) * 64'h0101010101010101;
                a[k*64 +: 64] = T_A[t];
                p[k*8 +: 8]   = T_P[t];
            end
            run_and_check("R1 R3 R5 R6 R7 R8 table", d, a, p, T_SZ[t], T_OP[t]);
        end
        // R1: valid lasts exactly one cycle
        @(negedge clk);
        check("R1 pulse", VL'(res_valid), '0);

        // R4: each 64-bit lane carries its own amount
        for (int k = 0; k < LN; k++) begin
            d[k*64 +: 64] = 64'hFFFF_FFFF_FFFF_FFFF;
            a[k*64 +: 64] = 64'(k + 1);
        end
        run_and_check("R4 per-lane", d, a, '1, 2'd1, 3'b001);

        // R7: 2^32+1 is out of range for bytes and halfwords too
        a = {LN{64'h0000000100000001}};
        run_and_check("R7 big lsl", d, a, '1, 2'd0, 3'b011);
        run_and_check("R7 big asr", {LN{64'h80FF7F0180FF7F01}}, a, '1, 2'd0, 3'b000);

        held = res;
        // R9: reserved size reports and writes nothing
        issue(~d, '0, '1, 2'd3, 3'b011);
        check("R9 undef", VL'(undef_enc), VL'(1));
        check("R9 no valid", VL'(res_valid), '0);
        check("R9 hold", res, held);

        // R2: foreign opcode does nothing
        issue(~d, '0, '1, 2'd0, 3'b010);
        check("R2 no valid", VL'(res_valid), '0);
        check("R2 no undef", VL'(undef_enc), '0);
        check("R2 hold", res, held);

        // Random sweep over all sizes and operations
        for (int i = 0; i < 60; i++) begin
            logic [2:0] oc;
            for (int k = 0; k < VL / 32; k++) begin
                d[k*32 +: 32] = $urandom;
                a[k*32 +: 32] = ((k % 2) == 1 && ($urandom % 4) != 0) ? 32'd0 : ($urandom % 40);
            end
            for (int k = 0; k < PW / 8; k++) p[k*8 +: 8] = 8'($urandom);
            case (i % 3)
                0:       oc = 3'b000;
                1:       oc = 3'b001;
                default: oc = 3'b011;
            endcase
            run_and_check("R3 R5 R8 random", d, a, p, 2'((i / 3) % 3), oc);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule